// File: doc/BRIEF.md
# Real-Time Clock Alarm Status and Control Register

This block sits beside the time-keeping counters of a real-time clock. It compares the live clock and calendar fields against a set of alarm fields. Only the fields whose per-field enable bit is 1 take part in the comparison. When that comparison becomes true, the block sets a sticky alarm flag. Software clears the flag by writing it. The block raises an alarm interrupt while both the flag and an interrupt-enable bit are set.

The block also holds an 8-bit control register for the clock. The register has separate power-on and manual reset values and keeps its contents while the chip is in standby. The register's bits only drive level outputs and one-cycle strobes. The counters, the periodic timer and the adjust arithmetic that use them are outside this block.

Software reaches both registers through a one-bit select, a write strobe with write data, and a combinational read-data bus.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: The alarm flag (status bit 0) becomes 1 at the first clock edge at which the enabled-field comparison is true and was false at the previous edge. "True" means every field with its enable bit at 1 equals the matching clock field.
- R2: Fields whose enable bit is 0 have no effect on the comparison, whatever their values.
- R3: With all enable bits at 0 the flag is never set.
- R4: Writing the status register (select 0) with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged.
- R5: If a new match and a clearing write fall on the same edge, the flag ends at 1.
- R6: Status bit 3 is the interrupt enable, written directly. It resets to 0. Status bits 7..4 and 2..1 read 0. `alarm_irq` is 1 exactly while both the enable and the flag are 1.
- R7: After power-on reset the control register (select 1) reads 0x09 and the status register reads 0x00.
- R8: Control bit layout, from bit 7 down to bit 0: periodic flag, periodic select[2:0], clock enable, adjust, divider reset, start. A write stores bits 7..3 and bit 0. The stored periodic flag, periodic select, clock enable and start drive `per_flag`, `per_sel`, `rtc_en` and `cnt_start` as levels.
- R9: Writing 1 to control bit 2 or bit 1 sets that bit. The bit reads 1 and drives `adj_strobe` or `divrst_strobe` for exactly the one cycle after the write edge, and then clears to 0.
- R10: Asserting `mrst` at an edge clears control bits 7..4 and 2..1, keeps bits 3 and 0, and clears the status register.
- R11: While `standby` is 1, writes to the control register are ignored and its contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| standby | input | 1 | Standby: holds the control register |
| cur_time | input | NUM_FIELDS*FIELD_W | Current clock/calendar fields, field 0 in the low bits |
| alarm_time | input | NUM_FIELDS*FIELD_W | Alarm fields, same packing |
| alarm_en | input | NUM_FIELDS | Per-field compare enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| alarm_irq | output | 1 | Alarm interrupt |
| per_flag | output | 1 | Stored periodic flag |
| per_sel | output | 3 | Stored periodic select |
| rtc_en | output | 1 | Clock enable level |
| cnt_start | output | 1 | Count start level |
| adj_strobe | output | 1 | One-cycle adjust strobe |
| divrst_strobe | output | 1 | One-cycle divider reset strobe |

## Verification
A field change or a register write takes effect at the next rising edge. The flag, the enable, the interrupt and the control contents are therefore due one edge after the stimulus, and a strobe is high only in the cycle after its write edge. Read data follows the select with no register in the path. The bench applies every stimulus just after a falling edge and samples at the following falling edge. Each result is read in its due cycle, and each strobe is read again one cycle later to confirm it has cleared.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   // Control register; field order is the register's bit layout (7..0)
   typedef struct packed {
      logic       per_flag;
      logic [2:0] per_sel;
      logic       rtc_en;
      logic       adj;
      logic       div_rst;
      logic       start;
   } rtc_ctl_t;

   localparam int          REG_W     = 8;
   localparam logic [7:0]  CTL_POR   = 8'h09;
   localparam logic [7:0]  CTL_KEEP  = 8'h09;   // bits surviving a manual reset
   localparam int          ST_FLAG   = 0;
   localparam int          ST_AIE    = 3;
   localparam logic        SEL_STAT  = 1'b0;
   localparam logic        SEL_CTRL  = 1'b1;

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int NUM_FIELDS = 4,
   parameter int FIELD_W    = 8,
   parameter int MATCH_PIPE = 0
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
   input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_time,
   input  logic [NUM_FIELDS-1:0]         alarm_en,
   output logic                          match_o
);

   logic [NUM_FIELDS-1:0] field_ok;
   logic                  hit;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      assign field_ok[i] = !alarm_en[i] ||
         (cur_time[i*FIELD_W +: FIELD_W] == alarm_time[i*FIELD_W +: FIELD_W]);
   end

   assign hit = (|alarm_en) && (&field_ok);

   if (MATCH_PIPE != 0) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) hit_q <= 1'b0;
         else        hit_q <= hit;
      end
      assign match_o = hit_q;
   end else begin : g_comb
      assign match_o = hit;

      // R3: no enabled field, no match
      p_no_enable_r3: assert property (@(posedge clk) disable iff (!por_n)
         (alarm_en == '0) |-> !match_o);

      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chk
         // R1/R2: a reported match implies each enabled field agrees
         p_field_eq_r1: assert property (@(posedge clk) disable iff (!por_n)
            (match_o && alarm_en[i]) |->
            (cur_time[i*FIELD_W +: FIELD_W] == alarm_time[i*FIELD_W +: FIELD_W]));
      end
   end

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
   import rtc_alarm_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst,
   input  logic             match,
   input  logic             stat_wr,
   input  logic [REG_W-1:0] stat_wdata,
   output logic             flag_o,
   output logic             aie_o
);

   logic match_q;
   logic set_ev;
   logic clr_ev;

   assign set_ev = match && !match_q;
   assign clr_ev = stat_wr && !stat_wdata[ST_FLAG];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         match_q <= 1'b0;
         flag_o  <= 1'b0;
         aie_o   <= 1'b0;
      end else if (mrst) begin
         match_q <= 1'b0;
         flag_o  <= 1'b0;
         aie_o   <= 1'b0;
      end else begin
         match_q <= match;
         if (set_ev)      flag_o <= 1'b1;   // set beats clear
         else if (clr_ev) flag_o <= 1'b0;
         if (stat_wr)     aie_o  <= stat_wdata[ST_AIE];
      end
   end

   p_set_r1: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(match) && !mrst) |=> flag_o);

   p_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
      (stat_wr && !stat_wdata[ST_FLAG] && !match && !mrst) |=> !flag_o);

   p_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
      (stat_wr && stat_wdata[ST_FLAG] && !match && !mrst) |=> (flag_o == $past(flag_o)));

   p_mrst_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
      mrst |=> (!flag_o && !aie_o));

endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
   import rtc_alarm_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst,
   input  logic             standby,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] ctl_wdata,
   output rtc_ctl_t         ctl_o
);

   rtc_ctl_t nxt;

   always_comb begin
      nxt         = ctl_o;
      nxt.adj     = 1'b0;
      nxt.div_rst = 1'b0;
      if (ctl_wr && !standby) nxt = rtc_ctl_t'(ctl_wdata);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    ctl_o <= rtc_ctl_t'(CTL_POR);
      else if (mrst) ctl_o <= rtc_ctl_t'(ctl_o & CTL_KEEP);
      else           ctl_o <= nxt;
   end

   p_mrst_r10: assert property (@(posedge clk) disable iff (!por_n)
      mrst |=> (ctl_o.per_flag == 1'b0 && ctl_o.per_sel == 3'd0 &&
                !ctl_o.adj && !ctl_o.div_rst &&
                ctl_o.rtc_en == $past(ctl_o.rtc_en) &&
                ctl_o.start == $past(ctl_o.start)));

   p_standby_r11: assert property (@(posedge clk) disable iff (!por_n)
      (standby && !mrst) |=>
      ({ctl_o.per_flag, ctl_o.per_sel, ctl_o.rtc_en, ctl_o.start} ==
       $past({ctl_o.per_flag, ctl_o.per_sel, ctl_o.rtc_en, ctl_o.start})));

   p_adj_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
      (ctl_o.adj && !(ctl_wr && ctl_wdata[2] && !standby)) |=> !ctl_o.adj);

   p_divrst_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
      (ctl_o.div_rst && !(ctl_wr && ctl_wdata[1] && !standby)) |=> !ctl_o.div_rst);

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
   import rtc_alarm_pkg::*;
#(
   parameter int NUM_FIELDS = 4,
   parameter int FIELD_W    = 8,
   parameter int MATCH_PIPE = 0,
   localparam int TIME_W    = NUM_FIELDS * FIELD_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst,
   input  logic              standby,
   input  logic [TIME_W-1:0] cur_time,
   input  logic [TIME_W-1:0] alarm_time,
   input  logic [NUM_FIELDS-1:0] alarm_en,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              alarm_irq,
   output logic              per_flag,
   output logic [2:0]        per_sel,
   output logic              rtc_en,
   output logic              cnt_start,
   output logic              adj_strobe,
   output logic              divrst_strobe
);

   if (NUM_FIELDS < 1) begin : g_bad_fields
      $error("rtc_alarm_ctrl: NUM_FIELDS must be at least 1");
   end
   if (FIELD_W < 1) begin : g_bad_width
      $error("rtc_alarm_ctrl: FIELD_W must be at least 1");
   end
   if (MATCH_PIPE != 0 && MATCH_PIPE != 1) begin : g_bad_pipe
      $error("rtc_alarm_ctrl: MATCH_PIPE must be 0 or 1");
   end

   logic     match;
   logic     flag;
   logic     aie;
   rtc_ctl_t ctl;
   logic [REG_W-1:0] stat_word;

   rtc_alarm_match #(
      .NUM_FIELDS (NUM_FIELDS),
      .FIELD_W    (FIELD_W),
      .MATCH_PIPE (MATCH_PIPE)
   ) u_match (
      .clk        (clk),
      .por_n      (por_n),
      .cur_time   (cur_time),
      .alarm_time (alarm_time),
      .alarm_en   (alarm_en),
      .match_o    (match)
   );

   rtc_alarm_flag u_flag (
      .clk        (clk),
      .por_n      (por_n),
      .mrst       (mrst),
      .match      (match),
      .stat_wr    (reg_wr && reg_sel == SEL_STAT),
      .stat_wdata (reg_wdata),
      .flag_o     (flag),
      .aie_o      (aie)
   );

   rtc_ctl_reg u_ctl (
      .clk       (clk),
      .por_n     (por_n),
      .mrst      (mrst),
      .standby   (standby),
      .ctl_wr    (reg_wr && reg_sel == SEL_CTRL),
      .ctl_wdata (reg_wdata),
      .ctl_o     (ctl)
   );

   always_comb begin
      stat_word          = '0;
      stat_word[ST_FLAG] = flag;
      stat_word[ST_AIE]  = aie;
   end

   assign reg_rdata     = (reg_sel == SEL_CTRL) ? REG_W'(ctl) : stat_word;
   assign alarm_irq     = aie && flag;
   assign per_flag      = ctl.per_flag;
   assign per_sel       = ctl.per_sel;
   assign rtc_en        = ctl.rtc_en;
   assign cnt_start     = ctl.start;
   assign adj_strobe    = ctl.adj;
   assign divrst_strobe = ctl.div_rst;

   p_irq_off_r6: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && reg_sel == SEL_STAT && !reg_wdata[ST_AIE]) |=> !alarm_irq);

endmodule

// File: tb/sim_rtc_alarm_ctrl.sv
module sim_rtc_alarm_ctrl;

   localparam int NF = 4;
   localparam int FW = 8;
   localparam int TW = NF * FW;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          mrst = 1'b0;
   logic          standby = 1'b0;
   logic [TW-1:0] cur_time = '0;
   logic [TW-1:0] alarm_time = 32'h3B17_0C2A;
   logic [NF-1:0] alarm_en = '0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          alarm_irq, per_flag, rtc_en, cnt_start, adj_strobe, divrst_strobe;
   logic [2:0]    per_sel;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   rtc_alarm_ctrl #(.NUM_FIELDS(NF), .FIELD_W(FW)) u0 (
      .clk(clk), .por_n(por_n), .mrst(mrst), .standby(standby),
      .cur_time(cur_time), .alarm_time(alarm_time), .alarm_en(alarm_en),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .alarm_irq(alarm_irq), .per_flag(per_flag),
      .per_sel(per_sel), .rtc_en(rtc_en), .cnt_start(cnt_start),
      .adj_strobe(adj_strobe), .divrst_strobe(divrst_strobe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   function automatic logic [TW-1:0] skew(input logic [TW-1:0] base, input logic [NF-1:0] mm);
      logic [TW-1:0] r = base;
      for (int i = 0; i < NF; i++)
         if (mm[i]) r[i*FW +: FW] = base[i*FW +: FW] ^ 8'h81;
      return r;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      logic       exp;
      logic       aie_w;
      repeat (3) @(negedge clk);
      // R7: power-on values
      rd(1'b1, d); chk("R7 ctrl por", d, 8'h09);
      rd(1'b0, d); chk("R7 status por", d, 8'h00);
      chk("R6 irq por", alarm_irq, 0);
      por_n = 1'b1;
      tick();
      chk("R8 rtc_en level", rtc_en, 1);
      chk("R8 start level", cnt_start, 1);

      // R1 R2 R3 R6: sweep enable masks and field mismatch patterns
      for (int en = 0; en < 16; en++) begin
         for (int mm = 0; mm < 16; mm++) begin
            aie_w    = mm[0] ^ en[0];
            alarm_en = NF'(en);
            cur_time = ~alarm_time;
            tick();
            wr(1'b0, {4'b0, aie_w, 3'b000});
            cur_time = skew(alarm_time, NF'(mm));
            tick();
            exp = (en != 0) && ((en & mm) == 0);
            rd(1'b0, d);
            chk(en == 0 ? "R3 no-enable flag" : "R1 R2 match flag", d, {4'b0, aie_w, 2'b00, exp});
            chk("R6 irq gating", alarm_irq, aie_w & exp);
         end
      end

      // R4: write one keeps, write zero clears
      alarm_en = 4'hF; cur_time = ~alarm_time; tick();
      wr(1'b0, 8'h00);
      wr(1'b0, 8'h01); rd(1'b0, d); chk("R4 write-one keeps 0", d[0], 0);
      cur_time = alarm_time; tick(); cur_time = ~alarm_time; tick();
      wr(1'b0, 8'h09); rd(1'b0, d); chk("R4 write-one keeps 1", d, 8'h09);
      chk("R6 irq on", alarm_irq, 1);
      wr(1'b0, 8'h08); rd(1'b0, d); chk("R4 write-zero clears", d, 8'h08);
      // R5: set wins over clear on the same edge
      cur_time = alarm_time;
      wr(1'b0, 8'h00); rd(1'b0, d); chk("R5 set wins", d[0], 1);
      cur_time = ~alarm_time; tick();

      // R8: writes store levels
      wr(1'b1, 8'hD9); rd(1'b1, d); chk("R8 ctrl store", d, 8'hD9);
      chk("R8 per_flag", per_flag, 1);
      chk("R8 per_sel", per_sel, 3'd5);
      wr(1'b1, 8'h30); chk("R8 rtc_en off", rtc_en, 0); chk("R8 start off", cnt_start, 0);

      // R9: pulse bits
      wr(1'b1, 8'h0D);
      chk("R9 adj strobe high", adj_strobe, 1);
      chk("R9 divrst quiet", divrst_strobe, 0);
      rd(1'b1, d); chk("R9 adj reads 1", d, 8'h0D);
      tick();
      chk("R9 adj strobe clears", adj_strobe, 0);
      rd(1'b1, d); chk("R9 adj reads 0", d, 8'h09);
      wr(1'b1, 8'h0B);
      chk("R9 divrst strobe high", divrst_strobe, 1);
      tick();
      chk("R9 divrst clears", divrst_strobe, 0);

      // R11: standby holds the control register
      standby = 1'b1;
      wr(1'b1, 8'hF6);
      rd(1'b1, d); chk("R11 standby ignores write", d, 8'h09);
      chk("R11 no strobe", adj_strobe | divrst_strobe, 0);
      standby = 1'b0;

      // R10: manual reset
      wr(1'b1, 8'hF8);
      wr(1'b0, 8'h08);
      cur_time = alarm_time; tick(); cur_time = ~alarm_time; tick();
      mrst = 1'b1; tick(); mrst = 1'b0;
      rd(1'b1, d); chk("R10 ctrl keeps bit3", d, 8'h08);
      rd(1'b0, d); chk("R10 status cleared", d, 8'h00);
      wr(1'b1, 8'hF1);
      mrst = 1'b1; tick(); mrst = 1'b0;
      rd(1'b1, d); chk("R10 ctrl keeps bit0", d, 8'h01);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule